// File: doc/BRIEF.md
# Interrupt Delivery and EOI Engine

This block decides, for each of its interrupt pins, whether a change on the incoming line turns into a message-signalled interrupt. It tracks the present level of every line. It applies edge or level semantics, masking, and remote-IRR coalescing for level pins. One pin, the tick pin, has an extra private hold flag. A tick source can use that flag to learn when its ticks were merged. Each delivered interrupt leaves the block as a 32-bit address and a 32-bit data word. Both are built from the pin's routing entry, which a separate storage block supplies as a flat input bus.

The processor side answers with end-of-interrupt broadcasts that carry a vector. The engine releases the matching state and then re-services every pin whose line is still high. It also re-services a pin when its routing entry is rewritten while the line is high. Line requests take the service slot before any queued re-service. Among queued re-services the lowest-numbered pin goes first, one pin per cycle.

Top module: `irq_deliver`

## Requirements
- R1: A deassert request (`req_level`=0) clears that pin's line-level bit. In the cycle after it, no message is issued.
- R2: An assert on an edge-mode pin (entry bit 12 = 0) whose line-level bit is already set is dropped and delivers nothing.
- R3: Any other assert sets the line-level bit. Delivery is still withheld if the mask bit (entry bit 13) is 1, or if the pin is level-mode (bit 12 = 1) with its remote IRR already set.
- R4: A delivery on the tick pin (default 8) in edge mode sets `tick_hold`. While `tick_hold` is 1, tick-pin asserts deliver nothing. Every assert on the tick pin pulses `tick_valid` one cycle later, and `tick_delivered` shows whether that assert produced a message.
- R5: A delivery on a level-mode pin sets that pin's `remote_irr` bit.
- R6: An EOI with vector V clears `tick_hold` if the tick pin's vector equals V. It also clears `remote_irr` on every level-mode pin whose vector (entry bits 7:0) equals V.
- R7: After an EOI, every pin whose line was high is serviced again as a fresh assert. This happens one pin per cycle, lowest pin number first, and only in cycles with no line request.
- R8: When `cfg_wr` marks a pin's entry as rewritten, an edge-mode entry has its `remote_irr` cleared. A level-mode, unmasked entry whose line is high is serviced again.
- R9: The entry layout is: vector in bits 7:0, delivery mode in 10:8, destination mode in 11, trigger in 12, mask in 13, destination ID in 21:14. The message address is 0xFEE in bits 31:20, the destination ID in 19:12 and the destination mode in bit 2, with zeros elsewhere. The data word holds the vector in 7:0, the delivery mode in 10:8 and the trigger in bit 15, with zeros elsewhere.
- R10: A request that triggers a delivery shows `msg_valid` in the cycle after it is sampled. A request whose pin number is NPINS or more changes nothing and delivers nothing.
- R11: After reset, line levels, remote IRR bits, `tick_hold`, `msg_valid` and `tick_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Line change request |
| req_pin | input | 5 | Pin of the request |
| req_level | input | 1 | New line level (1 assert, 0 deassert) |
| cfg_table | input | 528 | Routing entries, 22 bits per pin, pin 0 lowest |
| cfg_wr | input | 1 | Entry of `cfg_wr_pin` was rewritten |
| cfg_wr_pin | input | 5 | Pin whose entry was rewritten |
| eoi_valid | input | 1 | End-of-interrupt broadcast |
| eoi_vector | input | 8 | Vector carried by the EOI |
| msg_valid | output | 1 | Message issued this cycle |
| msg_pin | output | 5 | Source pin of the message |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |
| tick_valid | output | 1 | Status pulse for a tick-pin assert |
| tick_delivered | output | 1 | 1 if that assert was delivered, 0 if coalesced |
| line_level | output | 24 | Current line level per pin |
| remote_irr | output | 24 | Remote IRR per pin |
| tick_hold | output | 1 | Tick-pin coalescing flag |

## Verification
The bench goes after several corner cases.

- Repeated asserts on an edge pin. A design that forgot the level bit would emit duplicate messages.
- A tick pin asserted again before its EOI. A design that ignored the hold flag would deliver every tick and report no coalescing.
- An EOI that arrives while level lines are still high. Without re-injection the pins would stall forever with remote IRR clear.
- An EOI whose vector matches only some entries. A design that cleared remote IRR regardless of vector or trigger mode would reinject level interrupts early.
- Rewriting an entry to edge mode, or unmasking a pending level line. Getting this wrong leaves remote IRR stuck or loses the pending interrupt.
- Two pins re-serviced after one EOI. This exposes an arbiter that serves the wrong pin first.

// File: rtl/irq_deliver.sv
module irq_deliver #(
  parameter int NPINS    = 24,
  parameter int TICK_PIN = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [4:0]           req_pin,
  input  logic                 req_level,
  input  logic [NPINS*22-1:0]  cfg_table,
  input  logic                 cfg_wr,
  input  logic [4:0]           cfg_wr_pin,
  input  logic                 eoi_valid,
  input  logic [7:0]           eoi_vector,
  output logic                 msg_valid,
  output logic [4:0]           msg_pin,
  output logic [31:0]          msg_addr,
  output logic [31:0]          msg_data,
  output logic                 tick_valid,
  output logic                 tick_delivered,
  output logic [NPINS-1:0]     line_level,
  output logic [NPINS-1:0]     remote_irr,
  output logic                 tick_hold
);
  localparam int EW = 22;
  localparam logic [4:0] TICK = 5'(TICK_PIN);

  logic [7:0] vec_of  [NPINS];
  logic [2:0] dmd_of  [NPINS];
  logic       dsm_of  [NPINS];
  logic       trig_of [NPINS];
  logic       mask_of [NPINS];
  logic [7:0] dest_of [NPINS];

  for (genvar g = 0; g < NPINS; g++) begin : g_fld
    assign vec_of[g]  = cfg_table[g*EW +: 8];
    assign dmd_of[g]  = cfg_table[g*EW+8 +: 3];
    assign dsm_of[g]  = cfg_table[g*EW+11];
    assign trig_of[g] = cfg_table[g*EW+12];
    assign mask_of[g] = cfg_table[g*EW+13];
    assign dest_of[g] = cfg_table[g*EW+14 +: 8];
  end

  logic [NPINS-1:0] lvl_q, rirr_q, svc_q, lvl_n, rirr_n, svc_n;
  logic tick_q, tick_n;
  logic svc_hit;
  logic [4:0] svc_pin;

  always_comb begin
    svc_hit = 1'b0;
    svc_pin = '0;
    for (int i = NPINS-1; i >= 0; i--)
      if (svc_q[i]) begin
        svc_hit = 1'b1;
        svc_pin = 5'(i);
      end
  end

  wire req_ok   = {1'b0, req_pin} < 6'(NPINS);
  wire wr_ok    = {1'b0, cfg_wr_pin} < 6'(NPINS);
  wire req_up   = req_valid && req_level && req_ok;
  wire take_svc = !req_valid && svc_hit;
  wire [4:0] cand = req_up ? req_pin : svc_pin;
  wire cand_on  = req_up || (take_svc && lvl_q[svc_pin]);
  wire c_lvm    = trig_of[cand];
  wire c_ignore = !c_lvm && lvl_q[cand];
  wire c_go     = cand_on && !c_ignore && !mask_of[cand] &&
                  !(c_lvm && rirr_q[cand]) && !(cand == TICK && tick_q);

  always_comb begin
    lvl_n  = lvl_q;
    rirr_n = rirr_q;
    svc_n  = svc_q;
    tick_n = tick_q;
    if (take_svc) svc_n[svc_pin] = 1'b0;
    if (eoi_valid) begin
      if (vec_of[TICK_PIN] == eoi_vector) tick_n = 1'b0;
      for (int i = 0; i < NPINS; i++)
        if (trig_of[i] && vec_of[i] == eoi_vector) rirr_n[i] = 1'b0;
      svc_n = svc_n | lvl_q;
    end
    if (cfg_wr && wr_ok) begin
      if (!trig_of[cfg_wr_pin]) rirr_n[cfg_wr_pin] = 1'b0;
      else if (!mask_of[cfg_wr_pin] && lvl_q[cfg_wr_pin]) svc_n[cfg_wr_pin] = 1'b1;
    end
    if (req_valid && req_ok) begin
      if (!req_level) lvl_n[req_pin] = 1'b0;
      else if (!c_ignore) lvl_n[req_pin] = 1'b1;
    end
    if (c_go) begin
      if (c_lvm) rirr_n[cand] = 1'b1;
      else if (cand == TICK) tick_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0; rirr_q <= '0; svc_q <= '0; tick_q <= 1'b0;
      msg_valid <= 1'b0; msg_pin <= '0; msg_addr <= '0; msg_data <= '0;
      tick_valid <= 1'b0; tick_delivered <= 1'b0;
    end else begin
      lvl_q <= lvl_n; rirr_q <= rirr_n; svc_q <= svc_n; tick_q <= tick_n;
      msg_valid <= c_go;
      msg_pin   <= cand;
      msg_addr  <= {12'hFEE, dest_of[cand], 9'b0, dsm_of[cand], 2'b0};
      msg_data  <= {16'b0, c_lvm, 4'b0, dmd_of[cand], vec_of[cand]};
      tick_valid     <= req_up && req_pin == TICK;
      tick_delivered <= req_up && req_pin == TICK && c_go;
    end
  end

  assign line_level = lvl_q;
  assign remote_irr = rirr_q;
  assign tick_hold  = tick_q;
endmodule

// File: rtl/irq_deliver_chk.sv
module irq_deliver_chk #(
  parameter int NPINS    = 24,
  parameter int TICK_PIN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [4:0]       req_pin,
  input logic             req_level,
  input logic             msg_valid,
  input logic [4:0]       msg_pin,
  input logic [31:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic             tick_valid,
  input logic             tick_delivered,
  input logic [NPINS-1:0] remote_irr,
  input logic             tick_hold
);
  logic [NPINS-1:0] rirr_d;
  logic tick_d;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rirr_d <= '0;
      tick_d <= 1'b0;
    end else begin
      rirr_d <= remote_irr;
      tick_d <= tick_hold;
    end
  end

  AST_DEASSERT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_level |=> !msg_valid); // R1
  AST_LEVEL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_data[15] |-> !rirr_d[msg_pin]); // R3
  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_level && req_pin == 5'(TICK_PIN) |=> tick_valid); // R4
  AST_TICK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_valid && tick_delivered |-> !tick_d && msg_valid); // R4
  AST_LEVEL_SETS_RIRR: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_data[15] |-> remote_irr[msg_pin]); // R5
  AST_ADDR_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> msg_addr[31:20] == 12'hFEE && msg_addr[1:0] == 2'b0); // R9
  AST_BAD_PIN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && {1'b0, req_pin} >= 6'(NPINS) |=> !msg_valid); // R10
endmodule

bind irq_deliver irq_deliver_chk #(.NPINS(NPINS), .TICK_PIN(TICK_PIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin),
  .req_level(req_level), .msg_valid(msg_valid), .msg_pin(msg_pin),
  .msg_addr(msg_addr), .msg_data(msg_data), .tick_valid(tick_valid),
  .tick_delivered(tick_delivered), .remote_irr(remote_irr), .tick_hold(tick_hold));

// File: tb/irq_deliver_bench.sv
module irq_deliver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam int TP = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_level = 0, cfg_wr = 0, eoi_valid = 0;
  logic [4:0] req_pin = 0, cfg_wr_pin = 0;
  logic [7:0] eoi_vector = 0;
  logic [NP*22-1:0] cfg_table;
  logic msg_valid, tick_valid, tick_delivered, tick_hold;
  logic [4:0] msg_pin;
  logic [31:0] msg_addr, msg_data;
  logic [NP-1:0] line_level, remote_irr;

  irq_deliver u_irq_deliver (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [21:0] tbl [NP];
  bit [NP-1:0] m_lvl, m_rirr;
  bit m_tick;
  int exp_cnt [NP];
  int got_cnt [NP];
  int first_pin = -1;
  int total = 0, bad = 0;
  bit done = 0;

  always_comb for (int i = 0; i < NP; i++) cfg_table[i*22 +: 22] = tbl[i];

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && msg_valid) begin
    logic [21:0] e;
    e = tbl[msg_pin];
    got_cnt[msg_pin]++;
    if (first_pin < 0) first_pin = int'(msg_pin);
    check(msg_addr == {12'hFEE, e[21:14], 9'b0, e[11], 2'b0}, "R9 addr", msg_addr, {12'hFEE, e[21:14], 9'b0, e[11], 2'b0});
    check(msg_data == {16'b0, e[12], 4'b0, e[10:8], e[7:0]}, "R9 data", msg_data, {16'b0, e[12], 4'b0, e[10:8], e[7:0]});
  end

  // reference: fresh assert on pin p; returns delivered
  function automatic bit m_service(int p);
    bit lv = tbl[p][12];
    if (!lv && m_lvl[p]) return 0;
    m_lvl[p] = 1;
    if (tbl[p][13]) return 0;
    if (lv && m_rirr[p]) return 0;
    if (p == TP && m_tick) return 0;
    exp_cnt[p]++;
    if (lv) m_rirr[p] = 1;
    else if (p == TP) m_tick = 1;
    return 1;
  endfunction

  task automatic clear_counts();
    for (int i = 0; i < NP; i++) begin exp_cnt[i] = 0; got_cnt[i] = 0; end
    first_pin = -1;
  endtask

  task automatic settle(string req);
    bit ok = 1;
    repeat (30) @(negedge clk);
    for (int i = 0; i < NP; i++) if (got_cnt[i] != exp_cnt[i]) ok = 0;
    check(ok, {req, " msg counts"}, 0, 0);
    check(line_level == m_lvl, {req, " line_level"}, line_level, m_lvl);
    check(remote_irr == m_rirr, {req, " remote_irr"}, remote_irr, m_rirr);
    check(tick_hold == m_tick, {req, " tick_hold"}, tick_hold, m_tick);
  endtask

  task automatic do_req(int p, bit lv, string req);
    bit d = 0;
    clear_counts();
    if (p < NP) begin
      if (lv) d = m_service(p);
      else m_lvl[p] = 0;
    end
    @(posedge clk); #1;
    req_valid = 1; req_pin = 5'(p); req_level = lv;
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    if (lv && p < NP) check(msg_valid == d, {req, " R10 latency"}, msg_valid, d);
    if (!lv) check(!msg_valid, "R1 no msg on deassert", msg_valid, 0);
    if (p == TP && lv)
      check(tick_valid && tick_delivered == d, "R4 tick status", {tick_valid, tick_delivered}, {1'b1, d});
    settle(req);
  endtask

  task automatic do_eoi(logic [7:0] v, string req);
    clear_counts();
    if (tbl[TP][7:0] == v) m_tick = 0;
    for (int i = 0; i < NP; i++) if (tbl[i][12] && tbl[i][7:0] == v) m_rirr[i] = 0;
    for (int i = 0; i < NP; i++) if (m_lvl[i]) void'(m_service(i));
    @(posedge clk); #1;
    eoi_valid = 1; eoi_vector = v;
    @(posedge clk); #1;
    eoi_valid = 0;
    settle(req);
  endtask

  task automatic do_wr(int p, logic [21:0] val, string req);
    clear_counts();
    @(posedge clk); #1;
    tbl[p] = val;
    cfg_wr = 1; cfg_wr_pin = 5'(p);
    if (!val[12]) m_rirr[p] = 0;
    else if (!val[13] && m_lvl[p]) void'(m_service(p));
    @(posedge clk); #1;
    cfg_wr = 0;
    settle(req);
  endtask

  function automatic logic [21:0] mk(logic [7:0] v, bit lv, bit msk);
    return {8'($urandom), msk, lv, 1'($urandom), 3'($urandom), v};
  endfunction

  initial begin
    for (int i = 0; i < NP; i++) tbl[i] = 22'h002000;
    m_lvl = 0; m_rirr = 0; m_tick = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(line_level == 0 && remote_irr == 0 && !tick_hold && !msg_valid && !tick_valid,
          "R11 reset", {line_level, remote_irr}, 0);

    // R2 edge repeat
    do_wr(3, mk(8'h31, 0, 0), "R8 cfg edge");
    do_req(3, 1, "R2 first");
    do_req(3, 1, "R2 repeat ignored");
    check(got_cnt[3] == 0, "R2 repeat count", got_cnt[3], 0);
    do_req(3, 0, "R1 deassert");
    // R3 mask and level coalescing
    do_wr(17, mk(8'h32, 1, 1), "R3 cfg masked");
    do_req(17, 1, "R3 masked");
    do_wr(17, mk(8'h32, 1, 0), "R8 unmask pending level");
    check(got_cnt[17] == 1, "R8 unmask delivers", got_cnt[17], 1);
    do_req(17, 1, "R3 rirr coalesce");
    check(got_cnt[17] == 0, "R3 coalesced", got_cnt[17], 0);
    do_eoi(8'h32, "R6 R7 reinject");
    check(got_cnt[17] == 1, "R7 reinject count", got_cnt[17], 1);
    do_wr(17, mk(8'h32, 0, 0), "R8 edge clears rirr");
    check(remote_irr[17] == 0, "R8 rirr cleared", remote_irr[17], 0);
    do_req(17, 0, "R1 deassert 17");
    // R4 tick pin
    do_wr(TP, mk(8'h50, 0, 0), "R4 cfg");
    do_req(TP, 1, "R4 first tick");
    do_req(TP, 0, "R4 drop");
    do_req(TP, 1, "R4 coalesced tick");
    check(got_cnt[TP] == 0, "R4 coalesced count", got_cnt[TP], 0);
    do_eoi(8'h51, "R6 other vector keeps hold");
    do_eoi(8'h50, "R6 tick hold cleared");
    do_req(TP, 0, "R4 drop2");
    do_req(TP, 1, "R4 tick again");
    do_req(TP, 0, "R4 drop3");
    // R7 priority
    do_wr(5, mk(8'h40, 1, 0), "R7 cfg5");
    do_wr(2, mk(8'h40, 1, 0), "R7 cfg2");
    do_req(5, 1, "R5 level sets rirr 5");
    do_req(2, 1, "R5 level sets rirr 2");
    do_eoi(8'h40, "R7 two pins");
    check(first_pin == 2, "R7 lowest first", first_pin, 2);
    do_req(5, 0, "R1 d5");
    do_req(2, 0, "R1 d2");
    do_req(29, 1, "R10 bad pin");

    // random phase
    for (int n = 0; n < 300; n++) begin
      int sel = $urandom % 10;
      int pins [6] = '{3, 8, 8, 17, 23, 0};
      int p = pins[$urandom % 6];
      if (p == 0) p = $urandom % NP;
      if (sel < 5) do_req(p, 1'($urandom), "R3 random req");
      else if (sel < 7) do_eoi(8'h30 + 8'($urandom % 4), "R6 random eoi");
      else do_wr(p, mk(8'h30 + 8'($urandom % 4), 1'($urandom), ($urandom % 4) == 0), "R8 random wr");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule